// File: doc/BRIEF.md
# Serial-Programmed Lockable Wiper Register

This block is the digital side of a 64-step trimming resistor. It is a two-wire serial slave that holds a 6-bit wiper code and drives it onto `wiper_code` for the resistor ladder. Before the setting is made permanent, the host can write and read the code as often as it likes. A write whose instruction byte has its top bit set is a permanent-program request. It loads the code, locks the register, and runs a timed fuse-burn sequence. When the burn finishes, the code is frozen, even across later resets.

SCL and SDA are sampled on the system clock through two-flop synchronizers. START and STOP are recognised as SDA edges while SCL is high. SDA is driven open-drain style: `sda_oe` pulls the line to the level on `sda_o`, which is always low. The fuse array is modelled as a sticky flag and a stored code that reset does not clear. The burn length is a parameter counted in system clock cycles.

Top module: `otp_wiper_top`

## Requirements
- R1: After reset with an unburnt fuse, `wiper_code` is 0x20 and `burn_busy` is low.
- R2: The slave address is the 6-bit parameter `ADDR_BASE` followed by `addr_pin` as the least significant bit. Only a matching address byte is acknowledged. On a mismatch SDA is never pulled low for the rest of that transaction, and no state changes. A STOP returns the slave to idle.
- R3: A write is address+W, then an instruction byte, then a data byte, and both bytes are acknowledged. At the end of the data byte the wiper takes data bits 5:0 and ignores bits 7:6, as long as the register is not locked.
- R4: A read returns bytes of the form {validation[1:0] in bits 7:6, wiper code in bits 5:0}. The same byte is sent again after each master ACK, and SDA is released after a master NACK.
- R5: Bit 7 of the instruction byte set, on an unlocked register, loads the code and starts a burn. `burn_busy` rises and stays high for exactly `BURN_CYCLES` clock cycles.
- R6: Once a program request is accepted, later writes and later program requests change neither `wiper_code` nor `burn_busy`.
- R7: The validation field reads 00 until the burn has completed, including while it runs. It reads 11 when the burned code matches the wiper and 10 when they differ.
- R8: A reset after a completed burn restores the burned code, keeps the register locked and keeps the validation field at 11.
- R9: In a write, any byte after the data byte is not acknowledged and is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (acts as power-on) |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| addr_pin | input | 1 | Strap that supplies the address LSB |
| sda_oe | output | 1 | High to drive SDA with `sda_o` |
| sda_o | output | 1 | SDA drive level, always low (open-drain) |
| wiper_code | output | 6 | Current wiper position to the resistor ladder |
| burn_busy | output | 1 | High while the fuse-burn sequence runs |

## Verification
A wrong protocol state shows up within one bit time. It appears as a missing or extra acknowledge, or as a readback byte that differs from the expected byte. A lost or wrongly set lock shows up on the first write after programming, because `wiper_code` moves when it should stay still. A burn counter that is off by a cycle shows as a `burn_busy` pulse of the wrong length. A fuse store that reset disturbs shows up at the first sample after the reset, as the wrong wiper code and validation field.

// File: rtl/otp_wiper_pkg.sv
package otp_wiper_pkg;

    localparam int CODE_W = 6;
    localparam logic [CODE_W-1:0] MID_CODE = 6'h20;

    typedef logic [CODE_W-1:0] code_t;

    // Validation field in bits 7:6 of every read byte
    typedef enum logic [1:0] {
        VB_BLANK = 2'b00,
        VB_FAIL  = 2'b10,
        VB_GOOD  = 2'b11
    } vbits_e;

    typedef struct packed {
        logic  prog;
        code_t code;
    } wr_req_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INSTR,
        ST_INSTR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } bus_st_e;

    function automatic logic [7:0] pack_read(vbits_e vb, code_t c);
        return {vb, c};
    endfunction

endpackage

// File: rtl/wiper_bus_sync.sv
module wiper_bus_sync (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    // index 0: SCL, index 1: SDA
    logic [1:0] stg1, stg2, prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg1 <= 2'b11;
            stg2 <= 2'b11;
            prev <= 2'b11;
        end else begin
            stg1 <= {sda_i, scl_i};
            stg2 <= stg1;
            prev <= stg2;
        end
    end

    assign sda_s     = stg2[1];
    assign scl_rise  = stg2[0] && !prev[0];
    assign scl_fall  = !stg2[0] && prev[0];
    assign start_evt = stg2[0] && prev[0] && prev[1] && !stg2[1];
    assign stop_evt  = stg2[0] && prev[0] && !prev[1] && stg2[1];
endmodule

// File: rtl/wiper_i2c_slave.sv
module wiper_i2c_slave
    import otp_wiper_pkg::*;
#(
    parameter logic [5:0] ADDR_BASE = 6'b010110
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       addr_pin,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_evt,
    input  logic       stop_evt,
    input  logic [7:0] rd_byte,
    output logic       wr_valid,
    output wr_req_t    wr_req,
    output logic       sda_oe
);
    bus_st_e    state;
    logic [3:0] cnt;
    logic [7:0] sh, tx;
    logic       rw, prog_req, mack_n;
    logic       rx_state;

    assign rx_state = (state == ST_ADDR) || (state == ST_INSTR) || (state == ST_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            sh       <= '0;
            tx       <= '0;
            rw       <= 1'b0;
            prog_req <= 1'b0;
            mack_n   <= 1'b1;
            wr_valid <= 1'b0;
            wr_req   <= '0;
        end else begin
            wr_valid <= 1'b0;
            if (start_evt) begin
                state <= ST_ADDR;
                cnt   <= '0;
            end else if (stop_evt) begin
                state <= ST_IDLE;
            end else begin
                if (scl_rise) begin
                    sh <= {sh[6:0], sda_s};
                    if (rx_state) cnt <= cnt + 4'd1;
                    if (state == ST_TX_ACK) mack_n <= sda_s;
                end
                if (scl_fall) begin
                    unique case (state)
                        ST_ADDR: if (cnt == 4'd8) begin
                            if (sh[7:1] == {ADDR_BASE, addr_pin}) begin
                                rw    <= sh[0];
                                state <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                        ST_ADDR_ACK: begin
                            cnt <= '0;
                            if (rw) begin
                                tx    <= rd_byte;
                                state <= ST_TX;
                            end else begin
                                state <= ST_INSTR;
                            end
                        end
                        ST_INSTR: if (cnt == 4'd8) begin
                            prog_req <= sh[7];
                            state    <= ST_INSTR_ACK;
                        end
                        ST_INSTR_ACK: begin
                            cnt   <= '0;
                            state <= ST_DATA;
                        end
                        ST_DATA: if (cnt == 4'd8) begin
                            wr_valid <= 1'b1;
                            wr_req   <= '{prog: prog_req, code: sh[CODE_W-1:0]};
                            state    <= ST_DATA_ACK;
                        end
                        ST_DATA_ACK: state <= ST_IGNORE;
                        ST_TX: begin
                            tx  <= {tx[6:0], 1'b0};
                            cnt <= cnt + 4'd1;
                            if (cnt == 4'd7) state <= ST_TX_ACK;
                        end
                        ST_TX_ACK: begin
                            cnt <= '0;
                            if (!mack_n) begin
                                tx    <= rd_byte;
                                state <= ST_TX;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    assign sda_oe = (state == ST_ADDR_ACK) || (state == ST_INSTR_ACK) ||
                    (state == ST_DATA_ACK) || ((state == ST_TX) && !tx[7]);

    // R2: a STOP always returns the protocol engine to idle
    p_stop_idle_r2: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> state == ST_IDLE);
    // R3: a wiper request is only raised as the data byte completes
    p_wr_from_data_r3: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> $past(state) == ST_DATA);
    // R2: the slave never drives SDA while ignoring a transaction
    p_quiet_ignore_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE) |-> !sda_oe);
endmodule

// File: rtl/wiper_fuse_ctrl.sv
module wiper_fuse_ctrl
    import otp_wiper_pkg::*;
#(
    parameter int BURN_CYCLES = 100_000_000
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_valid,
    input  wr_req_t wr_req,
    output code_t   wiper,
    output vbits_e  vbits,
    output logic    busy
);
    localparam int CNT_W = $clog2(BURN_CYCLES + 1);

    logic [CNT_W-1:0] cnt;
    logic             locked;

    // Fuse array: starts blank and is never cleared by reset
    logic  fuse_blown = 1'b0;
    code_t fuse_code  = '0;

    always_ff @(posedge clk) begin
        if (!rst && busy && cnt == '0) begin
            fuse_blown <= 1'b1;
            fuse_code  <= wiper;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wiper  <= fuse_blown ? fuse_code : MID_CODE;
            locked <= fuse_blown;
            busy   <= 1'b0;
            cnt    <= '0;
        end else begin
            if (busy) begin
                if (cnt == '0) busy <= 1'b0;
                else           cnt  <= cnt - 1'b1;
            end
            if (wr_valid && !locked) begin
                wiper <= wr_req.code;
                if (wr_req.prog) begin
                    locked <= 1'b1;
                    busy   <= 1'b1;
                    cnt    <= CNT_W'(BURN_CYCLES - 1);
                end
            end
        end
    end

    always_comb begin
        if (!fuse_blown)              vbits = VB_BLANK;
        else if (fuse_code == wiper)  vbits = VB_GOOD;
        else                          vbits = VB_FAIL;
    end

    // R5: the burn only ends once the full count has elapsed
    p_burn_end_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(rst)) |-> $past(cnt) == '0);
    // R6: a locked wiper never moves outside reset
    p_lock_freeze_r6: assert property (@(posedge clk) disable iff (rst)
        (locked && $past(locked) && !$past(rst)) |-> $stable(wiper));
    // R7: validation stays blank while the burn runs
    p_busy_blank_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> vbits == VB_BLANK);
    // R8: a burnt fuse stays burnt
    p_fuse_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        $past(fuse_blown) |-> fuse_blown);
endmodule

// File: rtl/otp_wiper_top.sv
module otp_wiper_top
    import otp_wiper_pkg::*;
#(
    parameter logic [5:0] ADDR_BASE   = 6'b010110,
    parameter int         BURN_CYCLES = 100_000_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    input  logic        addr_pin,
    output logic        sda_oe,
    output logic        sda_o,
    output logic [5:0]  wiper_code,
    output logic        burn_busy
);
    logic    sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic    wr_valid;
    wr_req_t wr_req;
    code_t   wiper;
    vbits_e  vbits;

    wiper_bus_sync sync_i (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    wiper_i2c_slave #(.ADDR_BASE(ADDR_BASE)) slave_i (
        .clk(clk), .rst(rst), .addr_pin(addr_pin), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt),
        .rd_byte(pack_read(vbits, wiper)),
        .wr_valid(wr_valid), .wr_req(wr_req), .sda_oe(sda_oe)
    );

    wiper_fuse_ctrl #(.BURN_CYCLES(BURN_CYCLES)) fuse_i (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_req(wr_req),
        .wiper(wiper), .vbits(vbits), .busy(burn_busy)
    );

    assign sda_o      = 1'b0;
    assign wiper_code = wiper;
endmodule

// File: tb/otp_wiper_top_tb_top.sv
module otp_wiper_top_tb_top;
    localparam int         BURN = 2000;
    localparam int         Q    = 10;
    localparam logic [5:0] BASE = 6'b010110;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, master_sda = 1'b1, addr_pin = 1'b0;
    logic sda_line, sda_oe, sda_o, burn_busy;
    logic [5:0] wiper_code;

    int checks = 0, errors = 0, busy_cnt = 0;
    bit done = 1'b0;

    logic [5:0] m_wiper = 6'h20;
    logic [1:0] m_vb    = 2'b00;

    always #2 clk = ~clk;

    assign sda_line = master_sda & (sda_oe ? sda_o : 1'b1);

    otp_wiper_top #(.ADDR_BASE(BASE), .BURN_CYCLES(BURN)) dut_i (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .addr_pin(addr_pin), .sda_oe(sda_oe), .sda_o(sda_o),
        .wiper_code(wiper_code), .burn_busy(burn_busy)
    );

    always @(negedge clk) if (burn_busy) busy_cnt++;

    function automatic logic [7:0] exp_rd();
        return {m_vb, m_wiper};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic q_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        master_sda = 1'b1; scl_m = 1'b1; q_wait(Q);
        master_sda = 1'b0; q_wait(Q);
        scl_m = 1'b0; q_wait(Q);
    endtask

    task automatic bus_stop();
        master_sda = 1'b0; q_wait(Q);
        scl_m = 1'b1; q_wait(Q);
        master_sda = 1'b1; q_wait(2 * Q);
    endtask

    task automatic put_bit(input logic b);
        master_sda = b; q_wait(Q);
        scl_m = 1'b1; q_wait(2 * Q);
        scl_m = 1'b0; q_wait(Q);
    endtask

    task automatic get_bit(output logic b);
        master_sda = 1'b1; q_wait(Q);
        scl_m = 1'b1; q_wait(Q);
        b = sda_line; q_wait(Q);
        scl_m = 1'b0; q_wait(Q);
    endtask

    task automatic put_byte(input logic [7:0] v, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(a);
        acked = !a;
    endtask

    task automatic get_byte(input logic mack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!mack);
    endtask

    task automatic do_write(input logic [6:0] addr, input logic [7:0] instr,
                            input logic [7:0] data, input logic exp_ack);
        logic a;
        bus_start();
        put_byte({addr, 1'b0}, a);
        chk("R2 address ack", a, exp_ack);
        if (a) begin
            put_byte(instr, a);
            chk("R3 instruction ack", a, 1);
            put_byte(data, a);
            chk("R3 data ack", a, 1);
        end
        bus_stop();
    endtask

    task automatic do_read(input int nbytes, input string req);
        logic a;
        logic [7:0] v;
        bus_start();
        put_byte({BASE, addr_pin, 1'b1}, a);
        chk("R2 read address ack", a, 1);
        for (int i = 0; i < nbytes; i++) begin
            get_byte(i != nbytes - 1, v);
            chk(req, v, exp_rd());
        end
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic a;
        void'($urandom(32'h5eed1234));
        q_wait(6);
        rst = 1'b0;
        q_wait(4);
        // R1 reset state
        chk("R1 reset wiper", wiper_code, 6'h20);
        chk("R1 reset busy", burn_busy, 0);
        // R4 and R7 read before programming, repeated bytes
        do_read(3, "R4 R7 blank readback");

        // R3 random unlocked writes on both strap values
        for (int k = 0; k < 12; k++) begin
            addr_pin = 1'($urandom % 2);
            q_wait(4);
            d = 8'($urandom);
            do_write({BASE, addr_pin}, 8'($urandom) & 8'h7f, d, 1'b1);
            m_wiper = d[5:0];
            q_wait(4);
            chk("R3 wiper follows data[5:0]", wiper_code, m_wiper);
            do_read(1 + (k % 2), "R4 readback");
        end

        // R3 directed: upper data bits ignored
        do_write({BASE, addr_pin}, 8'h00, 8'hc0, 1'b1);
        m_wiper = 6'h00;
        q_wait(4);
        chk("R3 top data bits ignored", wiper_code, m_wiper);
        do_write({BASE, addr_pin}, 8'h3f, 8'h3f, 1'b1);
        m_wiper = 6'h3f;
        q_wait(4);
        chk("R3 full-scale code", wiper_code, m_wiper);

        // R2 wrong address: nack and no change
        do_write({BASE, !addr_pin}, 8'h00, 8'h11, 1'b0);
        q_wait(4);
        chk("R2 foreign address leaves wiper", wiper_code, m_wiper);
        do_write({~BASE, addr_pin}, 8'h00, 8'h12, 1'b0);
        q_wait(4);
        chk("R2 foreign base leaves wiper", wiper_code, m_wiper);

        // R9 trailing byte nacked and ignored
        bus_start();
        put_byte({BASE, addr_pin, 1'b0}, a);
        put_byte(8'h00, a);
        put_byte(8'h0a, a);
        put_byte(8'h15, a);
        chk("R9 trailing byte nack", a, 0);
        bus_stop();
        m_wiper = 6'h0a;
        q_wait(4);
        chk("R9 trailing byte ignored", wiper_code, m_wiper);

        // R5 program request
        chk("R5 no burn before request", busy_cnt, 0);
        do_write({BASE, addr_pin}, 8'h80, 8'he5, 1'b1);
        m_wiper = 6'h25;
        chk("R5 wiper loaded by program", wiper_code, m_wiper);
        chk("R5 burn running", burn_busy, 1);
        do_read(1, "R7 blank during burn");
        for (int w = 0; w < 4 * BURN && burn_busy; w++) q_wait(1);
        q_wait(2);
        chk("R5 burn length", busy_cnt, BURN);
        m_vb = 2'b11;
        do_read(2, "R7 good after burn");

        // R6 locked: writes and new program requests ignored
        do_write({BASE, addr_pin}, 8'h00, 8'h07, 1'b1);
        q_wait(4);
        chk("R6 write after lock", wiper_code, m_wiper);
        do_write({BASE, addr_pin}, 8'h80, 8'h19, 1'b1);
        q_wait(4);
        chk("R6 program after lock wiper", wiper_code, m_wiper);
        chk("R6 no second burn", busy_cnt, BURN);
        do_read(1, "R6 readback after lock");

        // R8 reset restores fused code
        q_wait(2);
        rst = 1'b1;
        q_wait(3);
        rst = 1'b0;
        q_wait(2);
        chk("R8 wiper after reset", wiper_code, 6'h25);
        chk("R8 busy after reset", burn_busy, 0);
        do_read(1, "R8 validation after reset");
        do_write({BASE, addr_pin}, 8'h00, 8'h33, 1'b1);
        q_wait(4);
        chk("R8 still locked after reset", wiper_code, 6'h25);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule